// File: doc/BRIEF.md
# Serviced Countdown Watchdog

This block is a watchdog timer that sits on a 16-bit register bus. Software selects a timeout in half-second units and then sets the enable bit. From then on the block counts down by one on every pulse of a slow half-second tick input. If software stops servicing it, the count runs out and the block issues a one-cycle timeout reset request. The count is refilled only when software writes a fixed two-word key sequence, in the right order, to the service register.

Software can also program a pre-timeout warning level. When the remaining count reaches that level, a sticky status bit sets, and the interrupt line follows that bit while the interrupt is enabled. A write to the control register can request an immediate software reset. A cause register records which kind of reset the block requested last. Separate control bits freeze the countdown while the chip is in low-power, debug or wait state. An external alarm line can be driven directly by software, or it can be driven by a timeout when software selects that.

Two small state machines drive the block. The countdown machine has the states `T_OFF` (not enabled; the counter is held preloaded), `T_RUN` (counting ticks) and `T_HOLD` (frozen by a suspend condition). Its transitions are: `T_OFF`→`T_RUN` when enable is set; `T_OFF`→`T_HOLD` when enable is set while a suspend condition is active; `T_RUN`→`T_HOLD` when a suspend condition appears; and `T_HOLD`→`T_RUN` when that condition goes away. The key-sequence machine has the states `S_IDLE` and `S_ARMED`. Its transitions are: `S_IDLE`→`S_ARMED` on a write of 0x5555; and `S_ARMED`→`S_IDLE` on any service write. When that write is 0xAAAA, it also produces a reload.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, control reads 0x0030 (alarm-release bit 5 is 1, and bit 4 always reads 1). Every other register reads 0. The outputs `tout_rst_o`, `sw_rst_o`, `irq_o` and `ext_alarm_o` are all low.
- R2: Control bit 2 (enable) can be set by software but not cleared. Only reset clears it.
- R3: The timeout code sits in control bits [15:8]. Once enabled, `tout_rst_o` pulses for one cycle on the (code+1)-th tick. The counter then reloads and keeps counting.
- R4: A write of 0x5555 to the service register (byte offset 0x2), followed directly by a service write of 0xAAAA, reloads the count to code+1 ticks.
- R5: Any other service write after 0x5555 returns the key machine to idle and does not reload the count. This includes a second 0x5555.
- R6: A control write with bit 4 equal to 0 pulses `sw_rst_o` for one cycle. Bit 4 still reads back as 1.
- R7: The cause register (offset 0x4) reads 0x0001 after a software reset request and 0x0002 after a timeout. The later event replaces the earlier one.
- R8: Interrupt control (offset 0x6) holds the warning level in bits [7:0], the status in bit 14 and the enable in bit 15. Status sets when the remaining count reaches the warning level. Writing 1 to bit 14 clears it. `irq_o` equals status AND enable.
- R9: Control bits 0, 1 and 7 freeze the count while `lowpwr_i`, `debug_i` or `wait_i` respectively is high. With the matching bit clear, that input has no effect.
- R10: `ext_alarm_o` is high while control bit 5 is 0. It is also high after a timeout if control bit 3 was set.
- R11: Miscellaneous control (offset 0x8) bit 0 is a power-down-enable bit that reads back as written. Unmapped offsets and the service register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| tick_i | input | 1 | Half-second tick, one cycle wide |
| lowpwr_i | input | 1 | Chip is in low-power state |
| debug_i | input | 1 | Chip is halted for debug |
| wait_i | input | 1 | Chip is in wait state |
| tout_rst_o | output | 1 | One-cycle timeout reset request |
| sw_rst_o | output | 1 | One-cycle software reset request |
| irq_o | output | 1 | Pre-timeout interrupt |
| ext_alarm_o | output | 1 | External alarm line |

## Verification
The bench attacks the key sequence with wrong orders: a foreign word between the two keys, and a repeated first key. A detector that stays armed would reload on the trailing 0xAAAA and hide the timeout. It counts ticks exactly up to the expiry, so an off-by-one load (code instead of code+1) gives a pulse one tick early. It attempts to clear the enable bit; if the clear succeeds, the expiry disappears. It checks that suspend inputs freeze the count only when their control bit is set; swapped or ignored gating would show either an early pulse or a missing one. It also checks that the warning status sets on the exact tick and clears by write-one.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;
    typedef enum logic [1:0] {T_OFF, T_RUN, T_HOLD} tmr_state_e;
    typedef enum logic {S_IDLE, S_ARMED} seq_state_e;

    localparam logic [15:0] KEY_FIRST  = 16'h5555;
    localparam logic [15:0] KEY_SECOND = 16'hAAAA;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_SVC   = 4'h2;
    localparam logic [3:0] OFS_CAUSE = 4'h4;
    localparam logic [3:0] OFS_INT   = 4'h6;
    localparam logic [3:0] OFS_MISC  = 4'h8;
endpackage

// File: rtl/svc_wdog_seq.sv
module svc_wdog_seq
    import svc_wdog_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic         ok_o
);
    seq_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (wr_i && data_i == W'(KEY_FIRST)) nxt = S_ARMED;
            S_ARMED: if (wr_i) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_o <= 1'b0;
        else        ok_o <= wr_i && (state == S_ARMED) && (data_i == W'(KEY_SECOND));
    end

    // R4/R5: a reload is never followed directly by another one
    a_r5_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |=> !ok_o);
endmodule

// File: rtl/svc_wdog_timer.sv
module svc_wdog_timer
    import svc_wdog_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              hold_i,
    input  logic              tick_i,
    input  logic              reload_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CODE_W-1:0] warn_i,
    output logic              expire_o,
    output logic              warn_hit_o
);
    localparam int CNT_W = CODE_W + 1;

    tmr_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             step;

    assign load_val = {1'b0, code_i} + CNT_W'(1);
    assign step     = (state == T_RUN) && !hold_i && tick_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            T_OFF:   if (en_i) nxt = hold_i ? T_HOLD : T_RUN;
            T_RUN:   if (hold_i) nxt = T_HOLD;
            T_HOLD:  if (!hold_i) nxt = T_RUN;
            default: nxt = T_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_W'(1);
        end else if (state == T_OFF || reload_i) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= (cnt == CNT_W'(1)) ? load_val : cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expire_o   <= 1'b0;
            warn_hit_o <= 1'b0;
        end else begin
            expire_o   <= step && (cnt == CNT_W'(1));
            warn_hit_o <= step && ((cnt - CNT_W'(1)) == {1'b0, warn_i});
        end
    end

    // R3: a live counter never sits at zero
    a_r3_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state != T_OFF) |-> (cnt != '0));
    // R2: once started the countdown cannot return to off
    a_r2_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state != T_OFF) |=> (state != T_OFF));
    // R9: a held count does not move unless serviced
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_HOLD && !reload_i) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    input  logic              tick_i,
    input  logic              lowpwr_i,
    input  logic              debug_i,
    input  logic              wait_i,
    output logic              tout_rst_o,
    output logic              sw_rst_o,
    output logic              irq_o,
    output logic              ext_alarm_o
);
    logic [CODE_W-1:0] code_q, warn_q;
    logic lp_sus_q, dbg_sus_q, wait_sus_q, en_q, tsel_q, alarm_rel_q;
    logic [1:0] cause_q;
    logic sts_q, ie_q, pde_q, tout_seen_q;
    logic wr_ctrl, wr_svc, wr_int, wr_misc;
    logic hold, svc_ok, warn_hit;

    assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(OFS_CTRL);
    assign wr_svc  = wr_en_i && addr_i == ADDR_W'(OFS_SVC);
    assign wr_int  = wr_en_i && addr_i == ADDR_W'(OFS_INT);
    assign wr_misc = wr_en_i && addr_i == ADDR_W'(OFS_MISC);
    assign hold    = (lp_sus_q && lowpwr_i) || (dbg_sus_q && debug_i) || (wait_sus_q && wait_i);

    svc_wdog_seq #(.W(16)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_svc), .data_i(wdata_i), .ok_o(svc_ok)
    );

    svc_wdog_timer #(.CODE_W(CODE_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .hold_i(hold), .tick_i(tick_i),
        .reload_i(svc_ok), .code_i(code_q), .warn_i(warn_q),
        .expire_o(tout_rst_o), .warn_hit_o(warn_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0; wait_sus_q <= 1'b0; alarm_rel_q <= 1'b1; tsel_q <= 1'b0;
            en_q <= 1'b0; dbg_sus_q <= 1'b0; lp_sus_q <= 1'b0; sw_rst_o <= 1'b0;
        end else begin
            sw_rst_o <= wr_ctrl && !wdata_i[4];
            if (wr_ctrl) begin
                code_q      <= wdata_i[8 +: CODE_W];
                wait_sus_q  <= wdata_i[7];
                alarm_rel_q <= wdata_i[5];
                tsel_q      <= wdata_i[3];
                en_q        <= en_q | wdata_i[2];
                dbg_sus_q   <= wdata_i[1];
                lp_sus_q    <= wdata_i[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= 2'b00; warn_q <= '0; ie_q <= 1'b0; sts_q <= 1'b0;
            pde_q <= 1'b0; tout_seen_q <= 1'b0;
        end else begin
            if (sw_rst_o)        cause_q <= 2'b01;
            else if (tout_rst_o) cause_q <= 2'b10;
            tout_seen_q <= tout_seen_q | tout_rst_o;
            if (wr_int) begin
                warn_q <= wdata_i[CODE_W-1:0];
                ie_q   <= wdata_i[15];
            end
            if (warn_hit)                    sts_q <= 1'b1;
            else if (wr_int && wdata_i[14]) sts_q <= 1'b0;
            if (wr_misc) pde_q <= wdata_i[0];
        end
    end

    assign irq_o       = sts_q && ie_q;
    assign ext_alarm_o = !alarm_rel_q || (tsel_q && tout_seen_q);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFS_CTRL):  rdata_o = {code_q, wait_sus_q, 1'b0, alarm_rel_q, 1'b1,
                                           tsel_q, en_q, dbg_sus_q, lp_sus_q};
            ADDR_W'(OFS_CAUSE): rdata_o = {14'b0, cause_q};
            ADDR_W'(OFS_INT):   rdata_o = {ie_q, sts_q, 6'b0, warn_q};
            ADDR_W'(OFS_MISC):  rdata_o = {15'b0, pde_q};
            default:            rdata_o = '0;
        endcase
    end

    // R2: enable stays set until reset
    a_r2_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
    // R6: a software reset request follows a bus write
    a_r6_sw_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_o |-> $past(wr_en_i));
    // R7: at most one cause recorded
    a_r7_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_q));
endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
    logic lowpwr = 1'b0, debug = 1'b0, waitm = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic tout, swr, irq, alarm;
    int checks = 0, failures = 0, tout_cnt = 0, sw_cnt = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_watchdog u_svc_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .tick_i(tick), .lowpwr_i(lowpwr), .debug_i(debug),
        .wait_i(waitm), .tout_rst_o(tout), .sw_rst_o(swr), .irq_o(irq),
        .ext_alarm_o(alarm)
    );

    always @(negedge clk) begin
        if (tout) tout_cnt++;
        if (swr)  sw_cnt++;
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%04h exp=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lowpwr = 0; debug = 0; waitm = 0; tick = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; tout_cnt = 0; sw_cnt = 0;
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_values();
        logic [15:0] d;
        do_reset();
        rd(4'h0, d); check("R1 ctrl", d, 16'h0030);
        rd(4'h4, d); check("R1 cause", d, 16'h0000);
        rd(4'h6, d); check("R1 intctl", d, 16'h0000);
        check("R1 outputs", {12'b0, tout, swr, irq, alarm}, 16'h0000);
    endtask

    task automatic t_timeout();
        logic [15:0] d;
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3); idle(1); check("R3 no early expiry", 16'(tout_cnt), 16'd0);
        ticks(1); idle(2); check("R3 expiry on tick 4", 16'(tout_cnt), 16'd1);
        rd(4'h4, d); check("R7 cause timeout", d, 16'h0002);
        ticks(4); idle(1); check("R3 reload and repeat", 16'(tout_cnt), 16'd2);
    endtask

    task automatic t_enable_sticky();
        logic [15:0] d;
        do_reset();
        wr(4'h0, 16'h0034); wr(4'h0, 16'h0030);
        rd(4'h0, d); check("R2 enable held", d, 16'h0034);
        ticks(1); idle(1); check("R2 still counting", 16'(tout_cnt), 16'd1);
    endtask

    task automatic t_service_good();
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        ticks(3); idle(1); check("R4 service reloads", 16'(tout_cnt), 16'd0);
        ticks(1); idle(1); check("R4 expiry after reload", 16'(tout_cnt), 16'd1);
    endtask

    task automatic t_service_bad();
        do_reset();
        wr(4'h0, 16'h0334);
        ticks(3); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
        ticks(1); idle(1); check("R5 foreign word", 16'(tout_cnt), 16'd1);
        ticks(3); wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        ticks(1); idle(1); check("R5 repeated first key", 16'(tout_cnt), 16'd2);
        ticks(3); wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555);
        ticks(1); idle(1); check("R5 reversed order", 16'(tout_cnt), 16'd3);
    endtask

    task automatic t_sw_reset();
        logic [15:0] d;
        do_reset();
        wr(4'h0, 16'h0020); idle(1);
        check("R6 one pulse", 16'(sw_cnt), 16'd1);
        rd(4'h0, d); check("R6 bit4 reads 1", d, 16'h0030);
        rd(4'h4, d); check("R7 cause software", d, 16'h0001);
    endtask

    task automatic t_interrupt();
        logic [15:0] d;
        do_reset();
        wr(4'h6, 16'h8002); wr(4'h0, 16'h0734);
        ticks(5); idle(2);
        rd(4'h6, d); check("R8 status not yet", d, 16'h8002);
        ticks(1); idle(2);
        rd(4'h6, d); check("R8 status at level", d, 16'hC002);
        check("R8 irq high", {15'b0, irq}, 16'h0001);
        wr(4'h6, 16'hC002); idle(1);
        rd(4'h6, d); check("R8 w1c", d, 16'h8002);
        check("R8 irq low", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_suspend();
        do_reset();
        lowpwr = 1'b1; debug = 1'b1;
        wr(4'h0, 16'h0135);
        ticks(5); idle(1); check("R9 frozen in low power", 16'(tout_cnt), 16'd0);
        lowpwr = 1'b0; idle(2);
        ticks(2); idle(1); check("R9 debug ignored when unselected", 16'(tout_cnt), 16'd1);
    endtask

    task automatic t_alarm();
        do_reset();
        wr(4'h0, 16'h0014); idle(1);
        check("R10 alarm by software", {15'b0, alarm}, 16'h0001);
        do_reset();
        wr(4'h0, 16'h003C); idle(1);
        check("R10 no alarm before timeout", {15'b0, alarm}, 16'h0000);
        ticks(1); idle(2);
        check("R10 alarm after timeout", {15'b0, alarm}, 16'h0001);
    endtask

    task automatic t_misc();
        logic [15:0] d;
        do_reset();
        wr(4'h8, 16'hFFFF);
        rd(4'h8, d); check("R11 misc readback", d, 16'h0001);
        rd(4'h2, d); check("R11 service reads 0", d, 16'h0000);
        rd(4'hA, d); check("R11 unmapped", d, 16'h0000);
    endtask

    initial begin
        t_reset_values();
        t_timeout();
        t_enable_sticky();
        t_service_good();
        t_service_bad();
        t_sw_reset();
        t_interrupt();
        t_suspend();
        t_alarm();
        t_misc();
        finish_run();
    end
endmodule